// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between an 8-bit processor's 16-bit address bus and the memories and devices of a small computer that carries 128 KB of banked RAM. For every access it names one target (boot ROM, RAM, keyboard matrix window, 2 KB video RAM or printer status port), forms the physical RAM address and the video RAM address, and steers the selected target's read data back to the processor. Any address that reaches no target reads as 0xFF, and writes to it are dropped.

Four software-written controls shape the decode: a 2-bit layout mode, a boot-ROM overlay bit, a 3-bit bank command and a video page bit. Each is loaded by its own write strobe and applies from the cycle after the strobe. The bank command chooses, separately for each 32 KB half of the processor space, which 32 KB bank of physical RAM is seen. An undefined command leaves the banks as they were and raises a one-cycle error pulse. The address decode itself is combinational: target select, RAM address, video address and read data follow the address and direction inputs in the same cycle.

Top module: `bank_mem_decoder`

## Requirements
- R1: `sel` is one-hot or all zero, with bit 0 ROM, bit 1 RAM, bit 2 keyboard, bit 3 video and bit 4 printer; all zero means the access reaches nothing.
- R2: Layout 0: address 0x37E8 selects the printer for reads and writes; otherwise addresses below `ROM_BYTES` read ROM, 0x3800–0x3BFF read the keyboard, 0x3C00–0x3FFF select video, 0x4000 and above select RAM, and the rest is unmapped.
- R3: Layout 1: 0x3800–0x3BFF read the keyboard, 0x3C00–0x3FFF select video, and every other address selects RAM, except as R9 and R12 state for the overlay.
- R4: Layout 2: 0x0000–0xF3FF select RAM, 0xF400–0xF7FF read the keyboard, 0xF800–0xFFFF select video with `vid_addr` equal to the address minus 0xF800.
- R5: Layout 3: every address, for reads and writes, selects RAM.
- R6: When RAM is selected, `ram_addr` equals the address plus 32768 times the bank of the half named by address bit 15 (bit 15 clear: low-half bank; set: high-half bank).
- R7: Bank commands give (low bank, high bank): 0 → (0,0), 2 → (0,1), 3 → (0,2), 6 → (2,0), 7 → (3,0).
- R8: Commands 1, 4 and 5 leave both banks unchanged and drive `bank_err` high for exactly the one cycle after the strobe.
- R9: No write ever selects ROM or the keyboard; a layout-0 write below `ROM_BYTES` reaches nothing, and a layout-1 write there reaches RAM even with the overlay set.
- R10: `rdata` returns the selected target's read data, and 0xFF when `sel` is all zero.
- R11: In layouts 0 and 1 a video access gives `vid_addr` = page bit × 1024 + (address − 0x3C00).
- R12: With the overlay set, a layout-1 read below `ROM_BYTES` selects ROM; with it clear that read selects RAM; in layouts 2 and 3 the overlay changes nothing.
- R13: After reset the decoder is in layout 0, banks (0,0), video page 0, overlay set; a control strobe takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Load layout mode |
| mode_in | input | 2 | New layout mode |
| ovl_we | input | 1 | Load overlay bit |
| ovl_in | input | 1 | New overlay bit |
| bank_we | input | 1 | Load bank command |
| bank_cmd | input | 3 | Bank command |
| page_we | input | 1 | Load video page bit |
| page_in | input | 1 | New video page bit |
| addr | input | 16 | Processor address |
| wr | input | 1 | 1 for a write access, 0 for a read |
| rom_rdata | input | 8 | Read data from ROM |
| ram_rdata | input | 8 | Read data from RAM |
| kbd_rdata | input | 8 | Read data from keyboard window |
| vid_rdata | input | 8 | Read data from video RAM |
| prn_rdata | input | 8 | Read data from printer status |
| sel | output | 5 | One-hot target select |
| ram_addr | output | 17 | Physical RAM address |
| vid_addr | output | 11 | Video RAM address |
| rdata | output | 8 | Read data to processor |
| bank_err | output | 1 | One-cycle pulse on undefined bank command |

## Verification
The select, both addresses and the read data are combinational in the address and direction, so the bench drives an access on a falling edge and samples one time unit later within the same cycle. Control strobes are driven for one rising edge and their effect is checked at the following falling edge, the first point where the new register value is visible. The error pulse is registered at that same edge, so it is sampled high at the falling edge right after the strobe and low at the falling edge one cycle later.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  localparam int ADDR_W   = 16;
  localparam int BANK_W   = 2;
  localparam int HALF_W   = ADDR_W - 1;
  localparam int RAM_AW   = HALF_W + BANK_W;
  localparam int VID_AW   = 11;
  localparam int DATA_W   = 8;
  localparam int CMD_W    = 3;
  localparam int MODE_W   = 2;
  localparam int N_TGT    = 5;

  // target index inside the one-hot select
  localparam int T_ROM = 0;
  localparam int T_RAM = 1;
  localparam int T_KBD = 2;
  localparam int T_VID = 3;
  localparam int T_PRN = 4;

  localparam logic [ADDR_W-1:0] PRN_PORT   = 16'h37E8;
  localparam logic [ADDR_W-1:0] LOW_RAM_LO = 16'h4000;
  localparam logic [ADDR_W-1:0] HI_KBD_LO  = 16'hF400;
  localparam logic [ADDR_W-1:0] HI_VID_LO  = 16'hF800;
  localparam logic [5:0]        KBD_1K     = 6'b001110;
  localparam logic [5:0]        VID_1K     = 6'b001111;

  typedef struct packed {
    logic              ok;
    logic [BANK_W-1:0] lo;
    logic [BANK_W-1:0] hi;
  } bank_pair_t;

  function automatic bank_pair_t bank_lookup(input logic [CMD_W-1:0] cmd);
    bank_pair_t r;
    r = '{ok: 1'b1, lo: 2'd0, hi: 2'd0};
    case (cmd)
      3'd0:    r = '{ok: 1'b1, lo: 2'd0, hi: 2'd0};
      3'd2:    r = '{ok: 1'b1, lo: 2'd0, hi: 2'd1};
      3'd3:    r = '{ok: 1'b1, lo: 2'd0, hi: 2'd2};
      3'd6:    r = '{ok: 1'b1, lo: 2'd2, hi: 2'd0};
      3'd7:    r = '{ok: 1'b1, lo: 2'd3, hi: 2'd0};
      default: r = '{ok: 1'b0, lo: 2'd0, hi: 2'd0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bmd_ctrl.sv
module bmd_ctrl
  import bmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              ovl_we,
  input  logic              ovl_in,
  input  logic              bank_we,
  input  logic [CMD_W-1:0]  bank_cmd,
  input  logic              page_we,
  input  logic              page_in,
  output logic [MODE_W-1:0] mode_q,
  output logic              ovl_q,
  output logic              page_q,
  output logic [BANK_W-1:0] bank_lo_q,
  output logic [BANK_W-1:0] bank_hi_q,
  output logic              err_q
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [MODE_W-1:0] mode_d;
  logic              ovl_d;
  logic              page_d;
  logic [BANK_W-1:0] bank_lo_d;
  logic [BANK_W-1:0] bank_hi_d;
  logic              err_d;
  bank_pair_t        lk;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_comb begin
    lk        = bank_lookup(bank_cmd);
    mode_d    = mode_q;
    ovl_d     = ovl_q;
    page_d    = page_q;
    bank_lo_d = bank_lo_q;
    bank_hi_d = bank_hi_q;
    err_d     = 1'b0;
    if (mode_we) mode_d = mode_in;
    if (ovl_we)  ovl_d  = ovl_in;
    if (page_we) page_d = page_in;
    if (bank_we) begin
      if (lk.ok) begin
        bank_lo_d = lk.lo;
        bank_hi_d = lk.hi;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q    <= '0;
      ovl_q     <= 1'b1;
      page_q    <= 1'b0;
      bank_lo_q <= '0;
      bank_hi_q <= '0;
      err_q     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      ovl_q     <= ovl_d;
      page_q    <= page_d;
      bank_lo_q <= bank_lo_d;
      bank_hi_q <= bank_hi_d;
      err_q     <= err_d;
    end
  end

endmodule

// File: rtl/bmd_decode.sv
module bmd_decode
  import bmd_pkg::*;
#(
  parameter int ROM_BYTES = 'h3000
)(
  input  logic [MODE_W-1:0] mode,
  input  logic              ovl,
  input  logic              page,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [N_TGT-1:0]  sel,
  output logic [VID_AW-1:0] vid_addr
);

  localparam logic [ADDR_W-1:0] ROM_END = ADDR_W'(ROM_BYTES);

  logic in_rom, in_kbd_lo, in_vid_lo, in_ram_hi;
  logic [N_TGT-1:0] rd_only_kbd;

  assign in_rom    = addr < ROM_END;
  assign in_kbd_lo = addr[ADDR_W-1:10] == KBD_1K;
  assign in_vid_lo = addr[ADDR_W-1:10] == VID_1K;
  assign in_ram_hi = addr >= LOW_RAM_LO;
  assign rd_only_kbd = wr ? '0 : N_TGT'(1 << T_KBD);

  always_comb begin
    sel      = '0;
    vid_addr = {page, addr[9:0]};
    case (mode)
      2'd0: begin
        if (addr == PRN_PORT)  sel[T_PRN] = 1'b1;
        else if (in_rom)       sel[T_ROM] = !wr;
        else if (in_kbd_lo)    sel = rd_only_kbd;
        else if (in_vid_lo)    sel[T_VID] = 1'b1;
        else if (in_ram_hi)    sel[T_RAM] = 1'b1;
      end
      2'd1: begin
        if (ovl && in_rom && !wr) sel[T_ROM] = 1'b1;
        else if (in_kbd_lo)       sel = rd_only_kbd;
        else if (in_vid_lo)       sel[T_VID] = 1'b1;
        else                      sel[T_RAM] = 1'b1;
      end
      2'd2: begin
        if (addr < HI_KBD_LO)      sel[T_RAM] = 1'b1;
        else if (addr < HI_VID_LO) sel = rd_only_kbd;
        else begin
          sel[T_VID] = 1'b1;
          vid_addr   = addr[VID_AW-1:0];
        end
      end
      default: sel[T_RAM] = 1'b1;
    endcase
  end

endmodule

// File: rtl/bmd_rdmux.sv
module bmd_rdmux
  import bmd_pkg::*;
(
  input  logic [N_TGT-1:0]             sel,
  input  logic [N_TGT-1:0][DATA_W-1:0] src,
  output logic [DATA_W-1:0]            rdata
);

  logic [N_TGT-1:0][DATA_W-1:0] masked;

  genvar g;
  generate
    for (g = 0; g < N_TGT; g++) begin : g_mask
      assign masked[g] = src[g] & {DATA_W{sel[g]}};
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_TGT; i++) rdata = rdata | masked[i];
    if (sel == '0) rdata = '1;
  end

endmodule

// File: rtl/bank_mem_decoder.sv
module bank_mem_decoder
  import bmd_pkg::*;
#(
  parameter int ROM_BYTES = 'h3000
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_we,
  input  logic [1:0]  mode_in,
  input  logic        ovl_we,
  input  logic        ovl_in,
  input  logic        bank_we,
  input  logic [2:0]  bank_cmd,
  input  logic        page_we,
  input  logic        page_in,
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic [7:0]  rom_rdata,
  input  logic [7:0]  ram_rdata,
  input  logic [7:0]  kbd_rdata,
  input  logic [7:0]  vid_rdata,
  input  logic [7:0]  prn_rdata,
  output logic [4:0]  sel,
  output logic [16:0] ram_addr,
  output logic [10:0] vid_addr,
  output logic [7:0]  rdata,
  output logic        bank_err
);

  logic [MODE_W-1:0] mode_q;
  logic              ovl_q;
  logic              page_q;
  logic [BANK_W-1:0] bank_lo_q;
  logic [BANK_W-1:0] bank_hi_q;
  logic [BANK_W-1:0] bank_now;
  logic [N_TGT-1:0][DATA_W-1:0] src;

  bmd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_in   (mode_in),
    .ovl_we    (ovl_we),
    .ovl_in    (ovl_in),
    .bank_we   (bank_we),
    .bank_cmd  (bank_cmd),
    .page_we   (page_we),
    .page_in   (page_in),
    .mode_q    (mode_q),
    .ovl_q     (ovl_q),
    .page_q    (page_q),
    .bank_lo_q (bank_lo_q),
    .bank_hi_q (bank_hi_q),
    .err_q     (bank_err)
  );

  bmd_decode #(.ROM_BYTES(ROM_BYTES)) u_dec (
    .mode     (mode_q),
    .ovl      (ovl_q),
    .page     (page_q),
    .wr       (wr),
    .addr     (addr),
    .sel      (sel),
    .vid_addr (vid_addr)
  );

  // bank of the half addressed, scaled to 32 KB
  assign bank_now = addr[ADDR_W-1] ? bank_hi_q : bank_lo_q;
  assign ram_addr = {1'b0, addr} + {bank_now, {HALF_W{1'b0}}};

  assign src[T_ROM] = rom_rdata;
  assign src[T_RAM] = ram_rdata;
  assign src[T_KBD] = kbd_rdata;
  assign src[T_VID] = vid_rdata;
  assign src[T_PRN] = prn_rdata;

  bmd_rdmux u_mux (
    .sel   (sel),
    .src   (src),
    .rdata (rdata)
  );

endmodule

// File: rtl/bmd_checker.sv
module bmd_checker
  import bmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  sel,
  input logic        wr,
  input logic [7:0]  rdata,
  input logic [1:0]  mode,
  input logic [15:0] addr,
  input logic [10:0] vid_addr,
  input logic        bank_we,
  input logic [2:0]  bank_cmd,
  input logic [1:0]  bank_lo,
  input logic [1:0]  bank_hi,
  input logic        bank_err
);

  logic cmd_bad;
  assign cmd_bad = !bank_lookup(bank_cmd).ok;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R1

  AST_NO_ROM_KBD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (sel[T_ROM] == 1'b0 && sel[T_KBD] == 1'b0)); // R9

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 5'b0) |-> (rdata == 8'hFF)); // R10

  AST_LAYOUT3_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (sel == 5'b00010)); // R5

  AST_HIGH_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && addr >= 16'hF800) |-> (sel[T_VID] && vid_addr == addr[10:0])); // R4

  AST_BAD_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && cmd_bad) |=> (bank_err && $stable(bank_lo) && $stable(bank_hi))); // R8

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_we) |=> !bank_err); // R8

endmodule

bind bank_mem_decoder bmd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel      (sel),
  .wr       (wr),
  .rdata    (rdata),
  .mode     (mode_q),
  .addr     (addr),
  .vid_addr (vid_addr),
  .bank_we  (bank_we),
  .bank_cmd (bank_cmd),
  .bank_lo  (bank_lo_q),
  .bank_hi  (bank_hi_q),
  .bank_err (bank_err)
);

// File: tb/bank_mem_decoder_test.sv
module bank_mem_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROM_SZ     = 'h3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, ovl_we, bank_we, page_we;
  logic [1:0]  mode_in;
  logic        ovl_in, page_in;
  logic [2:0]  bank_cmd;
  logic [15:0] addr;
  logic        wr;
  logic [7:0]  rom_rdata, ram_rdata, kbd_rdata, vid_rdata, prn_rdata;
  logic [4:0]  sel;
  logic [16:0] ram_addr;
  logic [10:0] vid_addr;
  logic [7:0]  rdata;
  logic        bank_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench copy of the control state
  int s_mode = 0, s_ovl = 1, s_page = 0, s_lo = 0, s_hi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mem_decoder #(.ROM_BYTES(ROM_SZ)) uut (
    .clk(clk), .rst_n(rst_n),
    .mode_we(mode_we), .mode_in(mode_in),
    .ovl_we(ovl_we), .ovl_in(ovl_in),
    .bank_we(bank_we), .bank_cmd(bank_cmd),
    .page_we(page_we), .page_in(page_in),
    .addr(addr), .wr(wr),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .kbd_rdata(kbd_rdata),
    .vid_rdata(vid_rdata), .prn_rdata(prn_rdata),
    .sel(sel), .ram_addr(ram_addr), .vid_addr(vid_addr),
    .rdata(rdata), .bank_err(bank_err)
  );

  // read sources: distinct, address-dependent values
  assign rom_rdata = addr[7:0] ^ 8'h11;
  assign ram_rdata = addr[7:0] ^ 8'h22;
  assign kbd_rdata = addr[7:0] ^ 8'h33;
  assign vid_rdata = addr[7:0] ^ 8'h44;
  assign prn_rdata = addr[7:0] ^ 8'h55;

  task automatic chk(input string rq, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, got, exp);
    end
  endtask

  // expected target bit: 0 ROM,1 RAM,2 KBD,3 VID,4 PRN, -1 none
  function automatic int exp_tgt(int m, int ov, int w, int a);
    int kb = (a >= 'h3800 && a < 'h3C00);
    int vd = (a >= 'h3C00 && a < 'h4000);
    case (m)
      0: begin
        if (a == 'h37E8) return 4;
        if (a < ROM_SZ) return w ? -1 : 0;
        if (kb) return w ? -1 : 2;
        if (vd) return 3;
        if (a >= 'h4000) return 1;
        return -1;
      end
      1: begin
        if (ov && !w && a < ROM_SZ) return 0;
        if (kb) return w ? -1 : 2;
        if (vd) return 3;
        return 1;
      end
      2: begin
        if (a < 'hF400) return 1;
        if (a < 'hF800) return w ? -1 : 2;
        return 3;
      end
      default: return 1;
    endcase
  endfunction

  function automatic int exp_src(int t, int a);
    int lo = a & 'hFF;
    case (t)
      0: return lo ^ 'h11;
      1: return lo ^ 'h22;
      2: return lo ^ 'h33;
      3: return lo ^ 'h44;
      4: return lo ^ 'h55;
      default: return 'hFF;
    endcase
  endfunction

  function automatic string mode_req(int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic access(input int a, input int w, input string rq);
    int t, es, bk;
    string r;
    r = (rq == "") ? mode_req(s_mode) : rq;
    @(negedge clk);
    addr = a[15:0];
    wr   = w[0];
    #1;
    t  = exp_tgt(s_mode, s_ovl, w, a);
    es = (t < 0) ? 0 : (1 << t);
    chk(r, $sformatf("sel @%04h wr=%0d", a, w), int'(sel), es);
    if (t == 1) begin
      bk = (a >= 'h8000) ? s_hi : s_lo;
      chk("R6", $sformatf("ram_addr @%04h", a), int'(ram_addr), a + bk * 32768);
    end
    if (t == 3) begin
      if (s_mode == 2) chk("R4", $sformatf("vid_addr @%04h", a), int'(vid_addr), a - 'hF800);
      else chk("R11", $sformatf("vid_addr @%04h", a), int'(vid_addr), s_page * 1024 + (a - 'h3C00));
    end
    if (!w) chk("R10", $sformatf("rdata @%04h", a), int'(rdata), exp_src(t, a));
  endtask

  task automatic set_mode(input int m);
    @(negedge clk); mode_we = 1'b1; mode_in = m[1:0];
    @(negedge clk); mode_we = 1'b0;
    s_mode = m;
  endtask

  task automatic set_ovl(input int v);
    @(negedge clk); ovl_we = 1'b1; ovl_in = v[0];
    @(negedge clk); ovl_we = 1'b0;
    s_ovl = v;
  endtask

  task automatic set_page(input int v);
    @(negedge clk); page_we = 1'b1; page_in = v[0];
    @(negedge clk); page_we = 1'b0;
    s_page = v;
  endtask

  task automatic set_bank(input int c);
    int ok;
    ok = 1;
    case (c)
      0: begin s_lo = 0; s_hi = 0; end
      2: begin s_lo = 0; s_hi = 1; end
      3: begin s_lo = 0; s_hi = 2; end
      6: begin s_lo = 2; s_hi = 0; end
      7: begin s_lo = 3; s_hi = 0; end
      default: ok = 0;
    endcase
    @(negedge clk); bank_we = 1'b1; bank_cmd = c[2:0];
    @(negedge clk); bank_we = 1'b0;
    #1;
    chk(ok ? "R7" : "R8", $sformatf("bank_err after cmd %0d", c), int'(bank_err), ok ? 0 : 1);
    if (!ok) begin
      @(negedge clk); #1;
      chk("R8", "bank_err one cycle later", int'(bank_err), 0);
    end
  endtask

  function automatic int pick_addr();
    int corner[16] = '{'h0000, 'h2FFF, 'h3000, 'h37E7, 'h37E8, 'h37FF, 'h3800, 'h3BFF,
                       'h3C00, 'h3FFF, 'h4000, 'h7FFF, 'h8000, 'hF3FF, 'hF400, 'hF800};
    if ($urandom % 2) return corner[$urandom % 16];
    return $urandom % 65536;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    mode_we = 0; ovl_we = 0; bank_we = 0; page_we = 0;
    mode_in = 0; ovl_in = 0; page_in = 0; bank_cmd = 0;
    addr = 0; wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13: reset state seen through the decode
    #1;
    chk("R13", "bank_err after reset", int'(bank_err), 0);
    access('h0000, 0, "R13");      // layout 0, ROM
    access('h8123, 0, "R13");      // banks (0,0)
    access('h3C05, 0, "R13");      // page 0
    set_mode(1);
    access('h0100, 0, "R13");      // overlay set: ROM

    // R2 layout 0 directed
    set_mode(0);
    access('h2FFF, 0, "R2");
    access('h3000, 0, "R2");
    access('h37E8, 0, "R2");
    access('h37E8, 1, "R2");
    access('h3800, 0, "R2");
    access('h3FFF, 1, "R2");
    access('h0100, 1, "R9");       // ROM write discarded
    access('h3900, 1, "R9");       // keyboard not writable

    // R3, R9, R12 layout 1 overlay
    set_mode(1);
    access('h0100, 1, "R9");       // write reaches RAM
    access('h37E8, 0, "R3");
    set_ovl(0);
    access('h0100, 0, "R12");
    access('h2FFF, 0, "R12");

    // R11 page select
    set_page(1);
    access('h3C00, 0, "R11");
    access('h3FFF, 1, "R11");

    // R4 layout 2
    set_ovl(1);
    set_mode(2);
    access('h0000, 0, "R12");
    access('hF3FF, 0, "R4");
    access('hF400, 0, "R4");
    access('hF7FF, 1, "R4");
    access('hF800, 0, "R4");
    access('hFFFF, 1, "R4");

    // R5 layout 3
    set_mode(3);
    access('h0000, 0, "R12");
    access('h3C00, 0, "R5");
    access('h37E8, 1, "R5");

    // R7 every command, R6 both halves
    for (int c = 0; c < 8; c++) begin
      set_bank(c);
      access('h0000, 0, "R7");
      access('h8000, 0, "R7");
      access('hFFFF, 1, "R6");
    end
    set_bank(6);
    set_bank(4);                   // R8: must keep (2,0)
    access('h1234, 0, "R8");
    access('h9234, 0, "R8");

    // random mix
    for (int it = 0; it < 3000; it++) begin
      case ($urandom % 10)
        0: set_mode($urandom % 4);
        1: set_ovl($urandom % 2);
        2: set_bank($urandom % 8);
        3: set_page($urandom % 2);
        default: ;
      endcase
      access(pick_addr(), $urandom % 2, "");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule